// File: doc/BRIEF.md
# Posted Write Queue Bus Master

This block empties posted write transactions out of an external write queue onto a 64-bit internal system bus. The queue has two heads. The address head holds the already translated start address of the oldest transaction. The data head holds one 64-bit entry with eight byte enables, plus a marker on the final entry of that transaction. The block also receives a queue fill level in DWORDs and a flag that says the upstream side has finished or disconnected.

Once the queue holds enough data, the block requests the bus. After the grant it places the address, then streams data beats. Each beat is offered as 64 bits, and a beat the slave takes only as 32 bits is finished as two halves. The next bus address is held in a register that steps by 8 or by 4.

A burst can end in one of these ways:
- The transaction completes: the block returns to idle.
- Master abort: the transaction is flushed.
- Target abort, disconnect with data, latency-timer preemption or an empty queue: the block waits.

In the waiting state, a re-request rule decides when to ask for the bus again. That rule looks at the upstream flag, the fill level and the alignment of the next address. A master abort or target abort raises a one-cycle system-error pulse, each gated by its own enable bit.

The states are:
- ST_IDLE: no transaction under way.
- ST_REQ: requesting the bus.
- ST_ADDR: address phase.
- ST_DATA: data beats.
- ST_WAIT: stalled burst, bus released.
- ST_FLUSH: discarding a master-aborted transaction.

The transitions are:
- ST_IDLE→ST_REQ when the start rule holds.
- ST_REQ→ST_ADDR on grant.
- ST_ADDR→ST_FLUSH on master abort.
- ST_ADDR→ST_DATA on claim.
- ST_DATA→ST_IDLE on the final entry popped.
- ST_DATA→ST_WAIT on any of: target abort, disconnect, preemption or data starvation.
- ST_WAIT→ST_REQ when the re-request rule holds.
- ST_FLUSH→ST_IDLE when the final entry is discarded.

Top module: `pwq_drain_master`

## Requirements
- R1: After reset the block is idle. ib_req, aq_pop, dq_pop and serr are all 0.
- R2: From idle, ib_req rises only when aq_valid is 1 and either up_done is 1 or dq_dwords is at least REQ_DW (4). Otherwise ib_req stays 0.
- R3: In the cycle after a grant, ib_addr_valid is 1 and ib_addr carries the next address. For the first phase that is aq_addr. After a stop it is the address following the last accepted beat.
- R4: When ib_mabort answers the address phase, no data beat is driven. The block then pops every data entry up to and including the one with dq_last, pops the address entry, and returns to idle. serr is a one-cycle pulse, and only if cfg_mabort_serr_en is 1.
- R5: While ib_addr[2] is 0, the beat is offered as 64 bits: ib_wide is 1 and ib_wbe equals dq_be. If the slave answers ib_ack64, the entry is popped and the address steps by 8.
- R6: If the slave answers a 64-bit offer with ib_ack32 only, the entry stays and the address steps by 4. While ib_addr[2] is 1, the beat has ib_wide 0 and ib_wbe = {dq_be[7:4],4'b0000}. Its acceptance pops the entry and steps the address by 4.
- R7: Popping the entry marked dq_last pops the address entry in the same cycle. ib_req is 0 from the next cycle on.
- R8: A disconnect with data accepts the current beat. If that beat held the last entry, the block goes idle. Otherwise it drops ib_req and waits.
- R9: On target abort the current beat is not accepted and the block drops ib_req and waits. One cycle later, serr pulses if tabort_serr_en is 1, and up_disc pulses if up_active is 1.
- R10: Grant removal ends the burst only after the latency timer has counted LAT cycles since the address phase. Before that the burst continues.
- R11: From the waiting state, ib_req rises again only when up_done is 1, dq_dwords is at least 4, or bit 2 of the next address is 1.
- R12: If the data head is empty during a burst, the block drops ib_req and waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| aq_valid | input | 1 | Address queue head holds a transaction |
| aq_addr | input | AW | Translated start address of head transaction |
| aq_pop | output | 1 | Remove address head |
| dq_valid | input | 1 | Data queue head holds an entry |
| dq_data | input | 64 | Head entry data |
| dq_be | input | 8 | Head entry byte enables |
| dq_last | input | 1 | Head entry is the transaction's final one |
| dq_dwords | input | LVLW | DWORDs queued |
| dq_pop | output | 1 | Remove data head |
| up_done | input | 1 | Upstream transaction finished or disconnected |
| up_active | input | 1 | Upstream transaction still running |
| up_disc | output | 1 | Pulse asking the upstream side to disconnect |
| cfg_mabort_serr_en | input | 1 | Allow serr on master abort |
| tabort_serr_en | input | 1 | Allow serr on target abort |
| ib_req | output | 1 | Bus request |
| ib_gnt | input | 1 | Bus grant |
| ib_addr_valid | output | 1 | Address phase |
| ib_addr | output | AW | Current bus address |
| ib_claim | input | 1 | A slave claims the address |
| ib_mabort | input | 1 | No slave claims the address |
| ib_dvalid | output | 1 | Data beat offered |
| ib_wide | output | 1 | 1 = 64-bit offer, 0 = 32-bit beat |
| ib_wdata | output | 64 | Beat data |
| ib_wbe | output | 8 | Beat byte enables |
| ib_ack64 | input | 1 | Slave takes the beat as 64 bits |
| ib_ack32 | input | 1 | Slave takes the beat as 32 bits |
| ib_disc | input | 1 | Disconnect with data |
| ib_tabort | input | 1 | Target abort |
| serr | output | 1 | System error pulse |

## Verification
The assertions check the following on every cycle:
- The address steps by 8 after a 64-bit acceptance and by 4 after a 32-bit one.
- The lower byte enables are masked on upper-half beats.
- The request falls after completion.
- The flush state drives nothing onto the bus.
- The error pulse lasts one cycle.
- Entry into the request state from idle obeys the start rule, and entry from waiting obeys the re-request rule.

Only the bench scenarios can show the other behaviours:
- Which termination leads to which outcome, counted as the number of address phases.
- That a target-aborted beat is delivered exactly once later.
- That a flush consumes the whole transaction.
- That preemption depends on the latency timer.
- That the full beat sequence across both offsets and both slave widths matches the computed addresses, data and enables.

// File: rtl/pwq_pkg.sv
package pwq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_ADDR  = 3'd2,
        ST_DATA  = 3'd3,
        ST_WAIT  = 3'd4,
        ST_FLUSH = 3'd5
    } pwq_state_t;
endpackage

// File: rtl/pwq_req_gate.sv
module pwq_req_gate #(
    parameter int LVLW   = 6,
    parameter int REQ_DW = 4
) (
    input  logic            aq_valid,
    input  logic            up_done,
    input  logic [LVLW-1:0] dq_dwords,
    input  logic            unaligned,
    output logic            start_ok,
    output logic            resume_ok
);
    localparam logic [LVLW-1:0] REQ_LVL = LVLW'(REQ_DW);

    logic fill_ok;

    always_comb begin
        fill_ok   = (dq_dwords >= REQ_LVL);
        start_ok  = aq_valid && (up_done || fill_ok);
        resume_ok = up_done || fill_ok || unaligned;
    end
endmodule

// File: rtl/pwq_addr_track.sv
module pwq_addr_track #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step8,
    input  logic          step4,
    output logic [AW-1:0] nxt_addr
);
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
        end else if (step8) begin
            addr_q <= addr_q + AW'(8);
        end else if (step4) begin
            addr_q <= addr_q + AW'(4);
        end
    end

    assign nxt_addr = addr_q;
endmodule

// File: rtl/pwq_lat_timer.sv
module pwq_lat_timer #(
    parameter int LAT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LAT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expired = (cnt_q == LIMIT);
endmodule

// File: rtl/pwq_err_gen.sv
module pwq_err_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic mab_evt,
    input  logic tab_evt,
    input  logic mab_en,
    input  logic tab_en,
    input  logic up_active,
    output logic serr,
    output logic up_disc
);
    logic serr_q;
    logic disc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            serr_q <= 1'b0;
            disc_q <= 1'b0;
        end else begin
            serr_q <= (mab_evt && mab_en) || (tab_evt && tab_en);
            disc_q <= tab_evt && up_active;
        end
    end

    assign serr    = serr_q;
    assign up_disc = disc_q;
endmodule

// File: rtl/pwq_drain_master.sv
module pwq_drain_master
    import pwq_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LVLW   = 6,
    parameter int REQ_DW = 4,
    parameter int LAT    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            aq_valid,
    input  logic [AW-1:0]   aq_addr,
    output logic            aq_pop,
    input  logic            dq_valid,
    input  logic [63:0]     dq_data,
    input  logic [7:0]      dq_be,
    input  logic            dq_last,
    input  logic [LVLW-1:0] dq_dwords,
    output logic            dq_pop,
    input  logic            up_done,
    input  logic            up_active,
    output logic            up_disc,
    input  logic            cfg_mabort_serr_en,
    input  logic            tabort_serr_en,
    output logic            ib_req,
    input  logic            ib_gnt,
    output logic            ib_addr_valid,
    output logic [AW-1:0]   ib_addr,
    input  logic            ib_claim,
    input  logic            ib_mabort,
    output logic            ib_dvalid,
    output logic            ib_wide,
    output logic [63:0]     ib_wdata,
    output logic [7:0]      ib_wbe,
    input  logic            ib_ack64,
    input  logic            ib_ack32,
    input  logic            ib_disc,
    input  logic            ib_tabort,
    output logic            serr
);
    pwq_state_t st_q;
    pwq_state_t st_d;

    logic [AW-1:0] nxt_addr;
    logic          start_ok;
    logic          resume_ok;
    logic          lat_exp;
    logic          lat_clr;
    logic          beat_acc;
    logic          size8;
    logic          pop_entry;
    logic          last_done;
    logic          preempt;
    logic          mab_evt;
    logic          tab_evt;
    logic          load_addr;
    logic          step4;
    logic          flush_pop;

    pwq_req_gate #(
        .LVLW  (LVLW),
        .REQ_DW(REQ_DW)
    ) u_gate (
        .aq_valid (aq_valid),
        .up_done  (up_done),
        .dq_dwords(dq_dwords),
        .unaligned(nxt_addr[2]),
        .start_ok (start_ok),
        .resume_ok(resume_ok)
    );

    pwq_addr_track #(
        .AW(AW)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_addr),
        .load_addr(aq_addr),
        .step8    (size8),
        .step4    (step4),
        .nxt_addr (nxt_addr)
    );

    pwq_lat_timer #(
        .LAT(LAT)
    ) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (lat_clr),
        .expired(lat_exp)
    );

    pwq_err_gen u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .mab_evt  (mab_evt),
        .tab_evt  (tab_evt),
        .mab_en   (cfg_mabort_serr_en),
        .tab_en   (tabort_serr_en),
        .up_active(up_active),
        .serr     (serr),
        .up_disc  (up_disc)
    );

    // Beat bookkeeping for the data phase
    always_comb begin
        beat_acc  = (st_q == ST_DATA) && dq_valid && (ib_ack64 || ib_ack32) && !ib_tabort;
        size8     = beat_acc && !nxt_addr[2] && ib_ack64;
        step4     = beat_acc && !size8;
        pop_entry = beat_acc && (size8 || nxt_addr[2]);
        last_done = pop_entry && dq_last;
        preempt   = !ib_gnt && lat_exp;
        tab_evt   = (st_q == ST_DATA) && ib_tabort;
        mab_evt   = (st_q == ST_ADDR) && ib_mabort;
        flush_pop = (st_q == ST_FLUSH) && dq_valid;
        load_addr = (st_q == ST_IDLE) && start_ok;
        lat_clr   = (st_q != ST_ADDR) && (st_q != ST_DATA);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_ok) st_d = ST_REQ;
            end
            ST_REQ: begin
                if (ib_gnt) st_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (ib_mabort)     st_d = ST_FLUSH;
                else if (ib_claim) st_d = ST_DATA;
            end
            ST_DATA: begin
                if (ib_tabort)      st_d = ST_WAIT;
                else if (last_done) st_d = ST_IDLE;
                else if (ib_disc)   st_d = ST_WAIT;
                else if (preempt)   st_d = ST_WAIT;
                else if (!dq_valid) st_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (resume_ok) st_d = ST_REQ;
            end
            ST_FLUSH: begin
                if (dq_valid && dq_last) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ib_req        = (st_q == ST_REQ) || (st_q == ST_ADDR) || (st_q == ST_DATA);
        ib_addr_valid = (st_q == ST_ADDR);
        ib_addr       = nxt_addr;
        ib_dvalid     = (st_q == ST_DATA) && dq_valid;
        ib_wide       = !nxt_addr[2];
        ib_wdata      = dq_data;
        ib_wbe        = nxt_addr[2] ? {dq_be[7:4], 4'h0} : dq_be;
        dq_pop        = pop_entry || flush_pop;
        aq_pop        = last_done || (flush_pop && dq_last);
    end
endmodule

// File: rtl/pwq_drain_chk.sv
module pwq_drain_chk
    import pwq_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LVLW   = 6,
    parameter int REQ_DW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input pwq_state_t      st,
    input logic [AW-1:0]   nxt_addr,
    input logic            aq_valid,
    input logic            up_done,
    input logic [LVLW-1:0] dq_dwords,
    input logic            aq_pop,
    input logic            ib_req,
    input logic            ib_addr_valid,
    input logic            ib_dvalid,
    input logic            ib_wide,
    input logic [7:0]      ib_wbe,
    input logic            ib_ack64,
    input logic            ib_ack32,
    input logic            ib_tabort,
    input logic            serr
);
    localparam logic [LVLW-1:0] LVL = LVLW'(REQ_DW);

    // R5
    step8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_dvalid && ib_wide && ib_ack64 && !ib_tabort) |=> (nxt_addr == $past(nxt_addr) + AW'(8)));

    // R6
    step4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_dvalid && ib_ack32 && !ib_tabort && !(ib_wide && ib_ack64)) |=> (nxt_addr == $past(nxt_addr) + AW'(4)));

    // R6
    half_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_dvalid && !ib_wide) |-> (ib_wbe[3:0] == 4'h0));

    // R7
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aq_pop |=> !ib_req);

    // R4
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FLUSH) |-> (!ib_req && !ib_dvalid && !ib_addr_valid));

    // R4
    serr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr |=> !serr);

    // R2
    start_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_IDLE && st == ST_REQ) |-> $past(aq_valid && (up_done || dq_dwords >= LVL)));

    // R11
    resume_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_WAIT && st == ST_REQ) |-> $past(up_done || dq_dwords >= LVL || nxt_addr[2]));
endmodule

bind pwq_drain_master pwq_drain_chk #(
    .AW    (AW),
    .LVLW  (LVLW),
    .REQ_DW(REQ_DW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st           (st_q),
    .nxt_addr     (nxt_addr),
    .aq_valid     (aq_valid),
    .up_done      (up_done),
    .dq_dwords    (dq_dwords),
    .aq_pop       (aq_pop),
    .ib_req       (ib_req),
    .ib_addr_valid(ib_addr_valid),
    .ib_dvalid    (ib_dvalid),
    .ib_wide      (ib_wide),
    .ib_wbe       (ib_wbe),
    .ib_ack64     (ib_ack64),
    .ib_ack32     (ib_ack32),
    .ib_tabort    (ib_tabort),
    .serr         (serr)
);

// File: tb/pwq_drain_master_bench.sv
`timescale 1ns/1ps
module pwq_drain_master_bench;
    localparam int AW = 32;
    localparam int LVLW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [63:0] ent_data [0:511];
    logic [7:0]  ent_be   [0:511];
    int ent_end = 0, avail_end = 0, txn_posted = 0;
    logic [31:0] base_r = '0;
    bit m64 = 1, up_done_r = 1, gnt_en = 1, mab_mode = 0;
    bit mab_en = 0, tab_en = 0, up_act_r = 0;
    bit ta_en = 0, dc_en = 0;
    int ta_at = 0, ta_base = 0, dc_at = 0, dc_base = 0;
    logic [LVLW-1:0] dw_r = 6'd4;

    int head = 0, txn_done = 0, nlog = 0, nphase = 0, nserr = 0, nupd = 0, ntab = 0, ndisc = 0, cyc = 0;
    logic [31:0] log_addr [0:511];
    logic [7:0]  log_be   [0:511];
    logic [63:0] log_data [0:511];
    logic        log_big  [0:511];
    logic [31:0] ph_addr  [0:511];

    logic aq_valid, aq_pop, dq_valid, dq_last, dq_pop, up_disc;
    logic ib_req, ib_gnt, ib_addr_valid, ib_claim, ib_mabort, ib_dvalid, ib_wide;
    logic ib_ack64, ib_ack32, ib_disc, ib_tabort, serr;
    logic [AW-1:0] ib_addr;
    logic [63:0] ib_wdata, dq_data;
    logic [7:0] ib_wbe, dq_be;

    assign aq_valid  = (txn_posted != txn_done);
    assign dq_valid  = aq_valid && (head < ent_end) && (head < avail_end);
    assign dq_data   = ent_data[head];
    assign dq_be     = ent_be[head];
    assign dq_last   = (head == ent_end - 1);
    assign ib_gnt    = ib_req && gnt_en;
    assign ib_claim  = ib_addr_valid && !mab_mode;
    assign ib_mabort = ib_addr_valid && mab_mode;
    assign ib_ack64  = ib_dvalid && ib_wide && m64;
    assign ib_ack32  = ib_dvalid && (!ib_wide || !m64);
    assign ib_tabort = ib_dvalid && ta_en && (nlog == ta_at) && (ntab == ta_base);
    assign ib_disc   = ib_dvalid && dc_en && (nlog == dc_at) && (ndisc == dc_base);

    pwq_drain_master #(.AW(AW), .LVLW(LVLW), .REQ_DW(4), .LAT(4)) u_pwq_drain_master (
        .clk(clk), .rst_n(rst_n), .aq_valid(aq_valid), .aq_addr(base_r), .aq_pop(aq_pop),
        .dq_valid(dq_valid), .dq_data(dq_data), .dq_be(dq_be), .dq_last(dq_last),
        .dq_dwords(dw_r), .dq_pop(dq_pop), .up_done(up_done_r), .up_active(up_act_r),
        .up_disc(up_disc), .cfg_mabort_serr_en(mab_en), .tabort_serr_en(tab_en),
        .ib_req(ib_req), .ib_gnt(ib_gnt), .ib_addr_valid(ib_addr_valid), .ib_addr(ib_addr),
        .ib_claim(ib_claim), .ib_mabort(ib_mabort), .ib_dvalid(ib_dvalid), .ib_wide(ib_wide),
        .ib_wdata(ib_wdata), .ib_wbe(ib_wbe), .ib_ack64(ib_ack64), .ib_ack32(ib_ack32),
        .ib_disc(ib_disc), .ib_tabort(ib_tabort), .serr(serr)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (dq_pop) head <= head + 1;
        if (aq_pop) txn_done <= txn_done + 1;
        if (ib_dvalid && (ib_ack64 || ib_ack32) && !ib_tabort) begin
            log_addr[nlog] <= ib_addr;
            log_be[nlog]   <= ib_wbe;
            log_data[nlog] <= ib_wdata;
            log_big[nlog]  <= ib_wide && ib_ack64;
            nlog <= nlog + 1;
        end
        if (ib_addr_valid && ib_claim) begin
            ph_addr[nphase] <= ib_addr;
            nphase <= nphase + 1;
        end
        if (serr) nserr <= nserr + 1;
        if (up_disc) nupd <= nupd + 1;
        if (ib_tabort) ntab <= ntab + 1;
        if (ib_disc) ndisc <= ndisc + 1;
    end

    int total = 0, fails = 0;
    int h0, lg0, ph0, se0, ud0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic post(input logic [31:0] base, input int n, input bit big);
        h0 = head; lg0 = nlog; ph0 = nphase; se0 = nserr; ud0 = nupd;
        for (int i = 0; i < n; i++) begin
            ent_data[h0+i] = {32'hA000_0000 + 32'(cyc + i), 32'h5000_0000 + 32'(i)};
            ent_be[h0+i]   = 8'hFF - 8'(i * 3);
        end
        base_r = base; m64 = big;
        ent_end = h0 + n; avail_end = h0 + n;
        txn_posted = txn_posted + 1;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (txn_done != txn_posted) @(negedge clk);
    endtask

    function automatic int mism(int k, logic [31:0] a, logic [7:0] be, logic [63:0] d, bit big);
        return (log_addr[k] !== a || log_be[k] !== be || log_data[k] !== d || log_big[k] !== big) ? 1 : 0;
    endfunction

    task automatic verify(input int n, input logic [31:0] base, input bit big, output int nexp, output int bad);
        logic [31:0] a;
        logic [7:0] be;
        int k;
        a = base; k = lg0; bad = 0;
        for (int e = 0; e < n; e++) begin
            be = ent_be[h0+e];
            if (!a[2]) begin
                if (big) begin
                    bad += mism(k, a, be, ent_data[h0+e], 1'b1); k++; a += 8;
                end else begin
                    bad += mism(k, a, be, ent_data[h0+e], 1'b0); k++; a += 4;
                    bad += mism(k, a, {be[7:4], 4'h0}, ent_data[h0+e], 1'b0); k++; a += 4;
                end
            end else begin
                bad += mism(k, a, {be[7:4], 4'h0}, ent_data[h0+e], 1'b0); k++; a += 4;
            end
        end
        nexp = k - lg0;
    endtask

    task automatic seq_checks(input int n, input logic [31:0] base, input bit big, input string req);
        int nexp, bad;
        verify(n, base, big, nexp, bad);
        check(nlog - lg0 == nexp, req, nlog - lg0, nexp);
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 150000);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int nexp, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!ib_req && !aq_pop && !dq_pop && !serr, "R1", {ib_req, aq_pop, dq_pop, serr}, 0);

        // R5 / R6 / R3 / R7 sweep over offset, slave width and length
        for (int off = 0; off < 2; off++) begin
            for (int w = 0; w < 2; w++) begin
                for (int n = 1; n <= 4; n++) begin
                    post(32'h1000 + 32'(n * 64) + 32'(off * 4), n, w == 1);
                    wait_done();
                    seq_checks(n, base_r, w == 1, w == 1 ? "R5" : "R6");
                    check(nphase - ph0 == 1 && ph_addr[ph0] == base_r, "R3", ph_addr[ph0], base_r);
                    check(!ib_req && head == ent_end, "R7", head, ent_end);
                end
            end
        end

        // R2 start rule
        up_done_r = 0; dw_r = 6'd2;
        post(32'h2000, 2, 1'b1);
        repeat (8) @(negedge clk);
        check(!ib_req, "R2", ib_req, 0);
        dw_r = 6'd4;
        @(negedge clk);
        check(ib_req, "R2", ib_req, 1);
        wait_done();
        seq_checks(2, base_r, 1'b1, "R2");
        up_done_r = 1;

        // R4 master abort
        for (int en = 0; en < 2; en++) begin
            mab_mode = 1; mab_en = en[0];
            post(32'h3000, 3, 1'b1);
            wait_done();
            repeat (2) @(negedge clk);
            check(nlog == lg0, "R4", nlog - lg0, 0);
            check(nserr - se0 == en, "R4", nserr - se0, en);
            check(head - h0 == 3 && !ib_req, "R4", head - h0, 3);
            mab_mode = 0;
        end

        // R9 target abort
        for (int c = 0; c < 4; c++) begin
            tab_en = c[0]; up_act_r = c[1];
            ta_en = 1; ta_base = ntab;
            post(32'h4000, 3, 1'b1);
            ta_at = lg0 + 1;
            wait_done();
            repeat (2) @(negedge clk);
            seq_checks(3, base_r, 1'b1, "R9");
            check(nserr - se0 == int'(c[0]), "R9", nserr - se0, int'(c[0]));
            check(nupd - ud0 == int'(c[1]), "R9", nupd - ud0, int'(c[1]));
            check(nphase - ph0 == 2 && ph_addr[ph0+1] == base_r + 8, "R3", ph_addr[ph0+1], base_r + 8);
            ta_en = 0;
        end

        // R8 disconnect with data
        for (int k = 0; k < 3; k++) begin
            dc_en = 1; dc_base = ndisc;
            post(32'h5000, 3, 1'b1);
            dc_at = lg0 + k;
            wait_done();
            seq_checks(3, base_r, 1'b1, "R8");
            check(nphase - ph0 == (k == 2 ? 1 : 2), "R8", nphase - ph0, k == 2 ? 1 : 2);
            dc_en = 0;
        end

        // R10 preemption by latency timer
        for (int s = 0; s < 2; s++) begin
            post(32'h6000, 14, 1'b1);
            @(negedge clk);
            while (!ib_addr_valid) @(negedge clk);
            repeat (s == 0 ? 1 : 8) @(negedge clk);
            gnt_en = 0;
            repeat (3) @(negedge clk);
            gnt_en = 1;
            wait_done();
            seq_checks(14, base_r, 1'b1, "R10");
            check(nphase - ph0 == (s == 0 ? 1 : 2), "R10", nphase - ph0, s == 0 ? 1 : 2);
        end

        // R12 data starvation
        up_done_r = 0;
        post(32'h7000, 4, 1'b1);
        avail_end = h0 + 2;
        @(negedge clk);
        while (!ib_addr_valid) @(negedge clk);
        dw_r = 6'd0;
        repeat (10) @(negedge clk);
        check(!ib_req && nlog - lg0 == 2, "R12", nlog - lg0, 2);
        avail_end = ent_end; up_done_r = 1;
        wait_done();
        seq_checks(4, base_r, 1'b1, "R12");
        check(nphase - ph0 == 2, "R12", nphase - ph0, 2);

        // R11 re-request rule: unaligned next address resumes, aligned one waits
        for (int u = 0; u < 2; u++) begin
            up_done_r = 0; dw_r = 6'd4;
            ta_en = 1; tab_en = 0; up_act_r = 0; ta_base = ntab;
            post(32'h8000, 2, 1'b0);
            ta_at = lg0 + (u == 0 ? 1 : 2);
            @(negedge clk);
            while (!ib_addr_valid) @(negedge clk);
            dw_r = 6'd0;
            repeat (10) @(negedge clk);
            if (u == 0) begin
                check(txn_done == txn_posted, "R11", txn_posted - txn_done, 0);
            end else begin
                check(!ib_req && txn_done != txn_posted, "R11", ib_req, 0);
                up_done_r = 1;
            end
            wait_done();
            seq_checks(2, base_r, 1'b0, "R11");
            check(nphase - ph0 == 2, "R11", nphase - ph0, 2);
            ta_en = 0; up_done_r = 1; dw_r = 6'd4;
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule